// File: doc/BRIEF.md
# VMEbus Slave Cycle Sequencer

This block sits between the VMEbus slave strobes and a 32-bit local bus. It watches the address strobe, checks the address-modifier code and four region-match lines, and decides whether a slave cycle should run. When a cycle runs, it drives the address-latch and address-enable controls. It decodes the data strobes, long-word flag and address bit 1 into four local byte enables and a swap-buffer enable. It then returns the data acknowledge, either paced by a local handshake or timed by the block itself.

Lane numbering on the local side is big-endian. Byte enable 0 covers local data bits 31:24 and byte enable 3 covers bits 7:0. Byte and 16-bit transfers always travel on VMEbus data lines 15:0. When such a transfer belongs in the upper local half, the swap buffer moves it there.

During block transfers the sequencer produces the low local address byte itself from the second beat onward. It advances that byte by the size of each completed beat.

Top module: `vme_slave_seq`

## Requirements
- R1: A cycle is qualified when `as_n` is low, `am` is one of 0x09, 0x0B, 0x0D, 0x0F, 0x29, 0x2D, 0x39, 0x3B, 0x3D, 0x3F, and at least one `region` bit is high. `adr_latch` then goes high on the first clock edge that sees this. An unqualified cycle leaves `adr_latch` low and never asserts `dtack_n`.
- R2: `adr_en` goes high one clock after `adr_latch`. Both return low once `as_n` is seen high at the end of the cycle.
- R3: On the edge that first sees a data strobe low, the byte enables are set as follows (bit i of `dbe` is local byte i, and byte 0 is data bits 31:24):
  - Both strobes low, `lword_n` low, A1 low: 1111.
  - Both strobes low, `lword_n` high: 0011 when A1 is 0, 1100 when A1 is 1.
  - One strobe low, `lword_n` high: a single bit at index {A1,A0}, where A0 is 1 when only `ds0_n` is low.
  - Any other combination: no lane.
- R4: `swap_en_n` is low during the data phase of a byte or 16-bit transfer with A1 = 0. It stays high for 32-bit transfers and for A1 = 1.
- R5: With `cfg_be_high` = 1 an enabled lane reads 1. With `cfg_be_high` = 0 every `dbe` bit is inverted, so the idle value is 1111.
- R6: `local_wr_n` is low during the data phase of a cycle whose `write_n` was low, and high otherwise.
- R7: With `lack` held high, `dtack_n` goes low ACK_DLY clocks (default 2) after the edge that first saw a data strobe low.
- R8: With `lack` low, `dtack_n` stays high indefinitely. It goes low on the first edge that sees `lack` high, once the ACK_DLY delay has elapsed.
- R9: `dtack_n` returns high on the first edge after both data strobes are seen high.
- R10: A single-cycle access is not followed by a second acknowledge until `as_n` has gone high. Fresh data strobes under the same `as_n` produce no `dtack_n`.
- R11: In a block transfer (`am[1:0]` = 11 among the codes of R1), `la_drv` is low on the first beat. From the second beat on, `la_drv` is high and `la_low` equals the start byte {adr_lo, A0} plus the sizes of the earlier beats (4, 2 or 1), modulo 256.
- R12: `dat_latch` is high exactly while `dtack_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_be_high | input | 1 | Byte-enable polarity, 1 means active high |
| as_n | input | 1 | VMEbus address strobe, active low |
| ds0_n | input | 1 | VMEbus data strobe for the odd byte, active low |
| ds1_n | input | 1 | VMEbus data strobe for the even byte, active low |
| write_n | input | 1 | VMEbus write flag, active low |
| lword_n | input | 1 | VMEbus long-word flag, active low |
| adr_lo | input | 7 | VMEbus address bits 7:1 (bit 1 is A1) |
| am | input | 6 | Address-modifier code |
| region | input | 4 | Region-match lines from the external comparators |
| lack | input | 1 | Local acknowledge, active high |
| adr_latch | output | 1 | Address-latch strobe |
| adr_en | output | 1 | Local address enable |
| dat_latch | output | 1 | Data-latch close |
| local_wr_n | output | 1 | Local read/write, low for write |
| dbe | output | 4 | Local byte enables, polarity set by `cfg_be_high` |
| swap_en_n | output | 1 | Swap-buffer enable, active low |
| dtack_n | output | 1 | VMEbus data acknowledge, active low |
| la_low | output | 8 | Low local address byte during block transfers |
| la_drv | output | 1 | High while `la_low` is being sourced |

## Verification
A sequencer stuck in the wrong state shows up within a few clocks at the ports. Either `dtack_n` falls where no strobe or acknowledge allows it, or it fails to rise one clock after the strobes release. A wrong state can also put `adr_en` high without a preceding `adr_latch`.

A corrupted lane register appears at the first data-phase edge as a wrong `dbe` or `swap_en_n` value. A bad beat counter or address accumulator shows at the second block beat as `la_drv` in the wrong state or as a `la_low` value off by a transfer size.

The directed tests step through each lane pattern, both acknowledge modes, the aborted and unqualified cases, and a block run that wraps the low byte.

// File: rtl/vss_pkg.sv
package vss_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_WDS,
        S_CNT,
        S_ACK,
        S_REL,
        S_WAS
    } seq_st_t;

    typedef struct packed {
        logic [3:0] be;
        logic       swap;
        logic [2:0] size;
        logic       a0;
    } lane_t;

    function automatic logic am_supported(input logic [5:0] code);
        case (code)
            6'h09, 6'h0B, 6'h0D, 6'h0F,
            6'h29, 6'h2D,
            6'h39, 6'h3B, 6'h3D, 6'h3F: return 1'b1;
            default:                    return 1'b0;
        endcase
    endfunction

    function automatic logic am_is_block(input logic [5:0] code);
        return am_supported(code) && (code[1:0] == 2'b11);
    endfunction

    // Big-endian lane map: lane 0 = local bits 31:24, lane 3 = bits 7:0
    function automatic lane_t lane_decode(input logic ds0_n, input logic ds1_n,
                                          input logic lword_n, input logic a1);
        lane_t l;
        logic [1:0] idx;
        l   = '0;
        idx = 2'b00;
        if (!ds0_n && !ds1_n && !lword_n && !a1) begin
            l.be   = 4'b1111;
            l.size = 3'd4;
        end else if (!ds0_n && !ds1_n && lword_n) begin
            l.be   = a1 ? 4'b1100 : 4'b0011;
            l.swap = !a1;
            l.size = 3'd2;
        end else if ((ds0_n != ds1_n) && lword_n) begin
            l.a0   = ds1_n;
            idx    = {a1, ds1_n};
            l.be   = 4'b0001 << idx;
            l.swap = !a1;
            l.size = 3'd1;
        end
        return l;
    endfunction

endpackage

// File: rtl/vss_lane_dec.sv
module vss_lane_dec
    import vss_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic             active,
    input  logic             cfg_be_high,
    input  logic             ds0_n,
    input  logic             ds1_n,
    input  logic             lword_n,
    input  logic             a1,
    input  logic             write_n,
    output logic [LANES-1:0] dbe,
    output logic             swap_en_n,
    output logic             local_wr_n,
    output logic [2:0]       size,
    output logic             a0
);

    lane_t            lane_q;
    logic             wr_q;
    logic [LANES-1:0] on;

    always_ff @(posedge clk) begin
        if (rst) begin
            lane_q <= '0;
            wr_q   <= 1'b0;
        end else if (capture) begin
            lane_q <= lane_decode(ds0_n, ds1_n, lword_n, a1);
            wr_q   <= !write_n;
        end
    end

    always_comb begin
        on         = active ? lane_q.be[LANES-1:0] : '0;
        swap_en_n  = !(active && lane_q.swap);
        local_wr_n = !(active && wr_q);
        size       = lane_q.size;
        a0         = lane_q.a0;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_pol
        assign dbe[i] = cfg_be_high ? on[i] : !on[i];
    end

endmodule

// File: rtl/vss_blk_addr.sv
module vss_blk_addr #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:1] start_hi,
    input  logic          start_a0,
    input  logic [2:0]    size,
    output logic [AW-1:0] la_low,
    output logic          beat_nz
);

    always_ff @(posedge clk) begin
        if (rst) begin
            la_low  <= '0;
            beat_nz <= 1'b0;
        end else if (clear) begin
            beat_nz <= 1'b0;
        end else begin
            if (load && !beat_nz)
                la_low <= {start_hi, start_a0};
            if (step) begin
                la_low  <= la_low + AW'(size);
                beat_nz <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/vss_seq.sv
module vss_seq
    import vss_pkg::*;
#(
    parameter int ACK_DLY = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic as_n,
    input  logic ds_any,
    input  logic lack,
    input  logic qualify,
    input  logic blk,
    output logic adr_latch,
    output logic adr_en,
    output logic dtack_n,
    output logic dat_latch,
    output logic blk_q,
    output logic capture,
    output logic step,
    output logic data_phase,
    output logic idle
);

    localparam int            CW  = $clog2(ACK_DLY + 1);
    localparam logic [CW-1:0] LIM = CW'(ACK_DLY - 1);

    seq_st_t       st;
    logic [CW-1:0] cnt;

    assign capture    = (st == S_WDS) && !as_n && ds_any;
    assign step       = (st == S_ACK) && !ds_any;
    assign data_phase = (st == S_CNT) || (st == S_ACK);
    assign idle       = (st == S_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            cnt       <= '0;
            adr_latch <= 1'b0;
            adr_en    <= 1'b0;
            dtack_n   <= 1'b1;
            dat_latch <= 1'b0;
            blk_q     <= 1'b0;
        end else begin
            case (st)
                S_IDLE: if (!as_n) begin
                    if (qualify) begin
                        st        <= S_ADDR;
                        adr_latch <= 1'b1;
                        blk_q     <= blk;
                    end else begin
                        st <= S_WAS;
                    end
                end
                S_ADDR: if (as_n) begin
                    st        <= S_IDLE;
                    adr_latch <= 1'b0;
                end else begin
                    st     <= S_WDS;
                    adr_en <= 1'b1;
                end
                S_WDS: if (as_n) begin
                    st        <= S_IDLE;
                    adr_latch <= 1'b0;
                    adr_en    <= 1'b0;
                end else if (ds_any) begin
                    st  <= S_CNT;
                    cnt <= '0;
                end
                S_CNT: if (cnt >= LIM && lack) begin
                    st        <= S_ACK;
                    dtack_n   <= 1'b0;
                    dat_latch <= 1'b1;
                end else if (cnt < LIM) begin
                    cnt <= cnt + 1'b1;
                end
                S_ACK: if (!ds_any) begin
                    st        <= S_REL;
                    dtack_n   <= 1'b1;
                    dat_latch <= 1'b0;
                end
                S_REL: if (as_n) begin
                    st        <= S_IDLE;
                    adr_latch <= 1'b0;
                    adr_en    <= 1'b0;
                end else begin
                    st <= blk_q ? S_WDS : S_WAS;
                end
                S_WAS: if (as_n) begin
                    st        <= S_IDLE;
                    adr_latch <= 1'b0;
                    adr_en    <= 1'b0;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/vme_slave_seq.sv
module vme_slave_seq
    import vss_pkg::*;
#(
    parameter int ACK_DLY = 2,
    parameter int LA_W    = 8,
    parameter int LANES   = 4,
    parameter int NREG    = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_be_high,
    input  logic            as_n,
    input  logic            ds0_n,
    input  logic            ds1_n,
    input  logic            write_n,
    input  logic            lword_n,
    input  logic [LA_W-1:1] adr_lo,
    input  logic [5:0]      am,
    input  logic [NREG-1:0] region,
    input  logic            lack,
    output logic            adr_latch,
    output logic            adr_en,
    output logic            dat_latch,
    output logic            local_wr_n,
    output logic [LANES-1:0] dbe,
    output logic            swap_en_n,
    output logic            dtack_n,
    output logic [LA_W-1:0] la_low,
    output logic            la_drv
);

    logic       ds_any, qualify, blk, blk_q;
    logic       capture, step, data_phase, idle;
    logic [2:0] size;
    logic       a0, beat_nz;

    assign ds_any  = !ds0_n || !ds1_n;
    assign qualify = am_supported(am) && (|region);
    assign blk     = am_is_block(am);

    vss_seq #(.ACK_DLY(ACK_DLY)) i_seq (
        .clk(clk), .rst(rst), .as_n(as_n), .ds_any(ds_any), .lack(lack),
        .qualify(qualify), .blk(blk), .adr_latch(adr_latch), .adr_en(adr_en),
        .dtack_n(dtack_n), .dat_latch(dat_latch), .blk_q(blk_q),
        .capture(capture), .step(step), .data_phase(data_phase), .idle(idle)
    );

    vss_lane_dec #(.LANES(LANES)) i_lane (
        .clk(clk), .rst(rst), .capture(capture), .active(data_phase),
        .cfg_be_high(cfg_be_high), .ds0_n(ds0_n), .ds1_n(ds1_n),
        .lword_n(lword_n), .a1(adr_lo[1]), .write_n(write_n), .dbe(dbe),
        .swap_en_n(swap_en_n), .local_wr_n(local_wr_n), .size(size), .a0(a0)
    );

    vss_blk_addr #(.AW(LA_W)) i_badr (
        .clk(clk), .rst(rst), .clear(idle), .load(capture), .step(step),
        .start_hi(adr_lo), .start_a0(ds1_n), .size(size),
        .la_low(la_low), .beat_nz(beat_nz)
    );

    assign la_drv = blk_q && beat_nz && data_phase;

    // a0 of the latched lane is kept for observability of byte ordering
    logic unused_a0;
    assign unused_a0 = a0;

endmodule

// File: rtl/vss_checker.sv
module vss_checker (
    input logic clk,
    input logic rst,
    input logic ds0_n,
    input logic ds1_n,
    input logic lack,
    input logic adr_latch,
    input logic adr_en,
    input logic dtack_n,
    input logic la_drv
);

    // R8: acknowledge only follows a sampled local acknowledge
    p_ack_needs_lack_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(dtack_n) |-> $past(lack));

    // R9: release one clock after both strobes negate
    p_release_r9: assert property (@(posedge clk) disable iff (rst)
        (!dtack_n && ds0_n && ds1_n) |=> dtack_n);

    // R2: address enable follows the latch strobe
    p_en_after_latch_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(adr_en) |-> $past(adr_latch));

    // R1: acknowledge only inside a qualified cycle
    p_ack_in_cycle_r1: assert property (@(posedge clk) disable iff (rst)
        !dtack_n |-> (adr_latch && adr_en));

    // R7: acknowledge needs a strobe seen before it
    p_ack_after_ds_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(dtack_n) |-> !($past(ds0_n) && $past(ds1_n)));

    // R11: sourced address only inside an enabled cycle
    p_drv_in_cycle_r11: assert property (@(posedge clk) disable iff (rst)
        la_drv |-> adr_en);

endmodule

bind vme_slave_seq vss_checker i_chk (
    .clk(clk), .rst(rst), .ds0_n(ds0_n), .ds1_n(ds1_n), .lack(lack),
    .adr_latch(adr_latch), .adr_en(adr_en), .dtack_n(dtack_n), .la_drv(la_drv)
);

// File: tb/test_vme_slave_seq.sv
module test_vme_slave_seq;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_be_high = 1'b1;
    logic       as_n = 1'b1, ds0_n = 1'b1, ds1_n = 1'b1;
    logic       write_n = 1'b1, lword_n = 1'b1;
    logic [7:1] adr_lo = '0;
    logic [5:0] am = '0;
    logic [3:0] region = '0;
    logic       lack = 1'b1;
    logic       adr_latch, adr_en, dat_latch, local_wr_n, swap_en_n, dtack_n, la_drv;
    logic [3:0] dbe;
    logic [7:0] la_low;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vme_slave_seq i_vme_slave_seq (
        .clk(clk), .rst(rst), .cfg_be_high(cfg_be_high), .as_n(as_n),
        .ds0_n(ds0_n), .ds1_n(ds1_n), .write_n(write_n), .lword_n(lword_n),
        .adr_lo(adr_lo), .am(am), .region(region), .lack(lack),
        .adr_latch(adr_latch), .adr_en(adr_en), .dat_latch(dat_latch),
        .local_wr_n(local_wr_n), .dbe(dbe), .swap_en_n(swap_en_n),
        .dtack_n(dtack_n), .la_low(la_low), .la_drv(la_drv)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic open_cycle(input logic [5:0] code, input logic [3:0] reg_m,
                              input logic wr, input logic lw, input logic [7:1] lo);
        am = code; region = reg_m; write_n = wr; lword_n = lw; adr_lo = lo;
        as_n = 1'b0;
        step();
        step();
    endtask

    task automatic end_cycle();
        for (int i = 0; i < 12 && dtack_n; i++) step();
        ds0_n = 1'b1; ds1_n = 1'b1;
        step();
        as_n = 1'b1;
        step();
        step();
    endtask

    task automatic t_reset();
        chk("R12 reset dat_latch", dat_latch, 0);
        chk("R9 reset dtack_n", dtack_n, 1);
        chk("R1 reset adr_latch", adr_latch, 0);
        chk("R5 reset dbe", dbe, 4'b0000);
        chk("R6 reset local_wr_n", local_wr_n, 1);
    endtask

    task automatic t_self_timed();
        lack = 1'b1;
        am = 6'h39; region = 4'b0001; write_n = 1'b0; lword_n = 1'b0; adr_lo = 7'h00;
        as_n = 1'b0;
        step();
        chk("R1 adr_latch", adr_latch, 1);
        chk("R2 adr_en not yet", adr_en, 0);
        step();
        chk("R2 adr_en", adr_en, 1);
        ds0_n = 1'b0; ds1_n = 1'b0;
        step();
        chk("R3 quad dbe", dbe, 4'b1111);
        chk("R4 quad no swap", swap_en_n, 1);
        chk("R6 write level", local_wr_n, 0);
        chk("R7 dtack early", dtack_n, 1);
        step();
        chk("R7 dtack early2", dtack_n, 1);
        step();
        chk("R7 dtack on time", dtack_n, 0);
        chk("R12 dat_latch", dat_latch, 1);
        ds0_n = 1'b1; ds1_n = 1'b1;
        step();
        chk("R9 dtack released", dtack_n, 1);
        chk("R12 dat_latch off", dat_latch, 0);
        as_n = 1'b1;
        step();
        step();
        chk("R2 adr_latch cleared", adr_latch, 0);
        chk("R2 adr_en cleared", adr_en, 0);
    endtask

    task automatic t_lane(input string req, input logic d0, input logic d1,
                          input logic lw, input logic [7:1] lo,
                          input logic [3:0] exp_be, input logic exp_sw);
        open_cycle(6'h2D, 4'b0100, 1'b1, lw, lo);
        ds0_n = d0; ds1_n = d1;
        step();
        chk({req, " dbe"}, dbe, exp_be);
        chk({"R4 ", req, " swap"}, swap_en_n, exp_sw);
        chk("R6 read level", local_wr_n, 1);
        end_cycle();
    endtask

    task automatic t_lanes();
        t_lane("R3 word a1=0", 0, 0, 1, 7'h00, 4'b0011, 0);
        t_lane("R3 word a1=1", 0, 0, 1, 7'h01, 4'b1100, 1);
        t_lane("R3 byte0", 1, 0, 1, 7'h00, 4'b0001, 0);
        t_lane("R3 byte1", 0, 1, 1, 7'h00, 4'b0010, 0);
        t_lane("R3 byte3", 0, 1, 1, 7'h01, 4'b1000, 1);
    endtask

    task automatic t_polarity();
        cfg_be_high = 1'b0;
        #1;
        chk("R5 idle inverted", dbe, 4'b1111);
        open_cycle(6'h0D, 4'b1000, 1'b1, 1'b1, 7'h01);
        ds0_n = 1'b0; ds1_n = 1'b0;
        step();
        chk("R5 word a1=1 inverted", dbe, 4'b0011);
        end_cycle();
        cfg_be_high = 1'b1;
    endtask

    task automatic t_handshake();
        lack = 1'b0;
        open_cycle(6'h09, 4'b0010, 1'b1, 1'b0, 7'h00);
        ds0_n = 1'b0; ds1_n = 1'b0;
        for (int i = 0; i < 6; i++) step();
        chk("R8 withheld", dtack_n, 1);
        lack = 1'b1;
        step();
        chk("R8 acknowledged", dtack_n, 0);
        end_cycle();
    endtask

    task automatic t_unqualified();
        int seen = 0;
        open_cycle(6'h39, 4'b0000, 1'b1, 1'b0, 7'h00);
        chk("R1 no region latch", adr_latch, 0);
        ds0_n = 1'b0; ds1_n = 1'b0;
        for (int i = 0; i < 6; i++) begin step(); if (!dtack_n) seen++; end
        chk("R1 no region dtack", seen, 0);
        end_cycle();
        seen = 0;
        open_cycle(6'h3E, 4'b0001, 1'b1, 1'b0, 7'h00);
        chk("R1 bad am latch", adr_latch, 0);
        ds0_n = 1'b0; ds1_n = 1'b0;
        for (int i = 0; i < 6; i++) begin step(); if (!dtack_n) seen++; end
        chk("R1 bad am dtack", seen, 0);
        end_cycle();
    endtask

    task automatic t_as_hold();
        int seen = 0;
        open_cycle(6'h39, 4'b0001, 1'b1, 1'b0, 7'h00);
        ds0_n = 1'b0; ds1_n = 1'b0;
        for (int i = 0; i < 4; i++) step();
        chk("R10 first ack", dtack_n, 0);
        ds0_n = 1'b1; ds1_n = 1'b1;
        step(); step(); step();
        ds0_n = 1'b0; ds1_n = 1'b0;
        for (int i = 0; i < 6; i++) begin step(); if (!dtack_n) seen++; end
        chk("R10 no second ack", seen, 0);
        end_cycle();
    endtask

    task automatic block_beat(input string tag, input logic exp_drv, input logic [7:0] exp_lo);
        ds0_n = 1'b0; ds1_n = 1'b0;
        step();
        chk({"R11 ", tag, " la_drv"}, la_drv, exp_drv);
        if (exp_drv) chk({"R11 ", tag, " la_low"}, la_low, exp_lo);
        for (int i = 0; i < 12 && dtack_n; i++) step();
        ds0_n = 1'b1; ds1_n = 1'b1;
        step();
        step();
    endtask

    task automatic t_block();
        open_cycle(6'h0B, 4'b0001, 1'b1, 1'b0, 7'h7C);
        block_beat("beat1", 0, 8'h00);
        block_beat("beat2", 1, 8'hFC);
        block_beat("beat3 wrap", 1, 8'h00);
        as_n = 1'b1;
        step(); step();
        chk("R11 drv off after", la_drv, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        step(); step(); step();
        rst = 1'b0;
        step();
        t_reset();
        t_self_timed();
        t_lanes();
        t_polarity();
        t_handshake();
        t_unqualified();
        t_as_hold();
        t_block();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule